// File: doc/BRIEF.md
# Countdown Watchdog Peripheral

This block is a watchdog timer with a small memory-mapped register window of two 32-bit words. Software programs a timeout in whole seconds and sets a run bit. It then keeps the system alive by setting a self-clearing kick bit. The kick reloads the countdown from the programmed timeout and restarts the current second. A prescaler turns the core clock into one tick per second, and the countdown steps down once per tick while the run bit is set.

If no kick arrives in time and the countdown runs out, the block raises a one-cycle request on one of two outputs: a system-reset request or a power-off request, selected by a control bit. It also sets a sticky expiry flag and stops itself. The block has two synchronous resets. `sys_rst` stands for the reset the watchdog itself provokes and leaves the expiry flag untouched. `por_rst` is the power-on reset and clears everything. This lets software read after a restart whether the watchdog caused it.

Top module: `wdog_window`

## Requirements
- R1: After `por_rst` the control word reads 0x0000_0008 (stopped, idle flag set), the timeout word reads DEFAULT_TIMEOUT, and both request outputs are low.
- R2: Bus address bit 2 selects the word: 0 gives the control word, 1 gives the timeout word. Control bit 0 is run, bit 1 the expiry flag, bit 2 the action (0 = reset request, 1 = power-off request), bit 3 reads as the inverse of run, bit 7 is the kick bit and always reads 0, and all other bits read 0.
- R3: A timeout write keeps only the low 10 bits (1 to 1023 seconds). When those bits are zero, the stored value is 1. The timeout word reads back the stored value.
- R4: While run is 1 the countdown steps once every TICKS_PER_SEC clocks. While run is 0 the countdown holds its value and the partial second is discarded, so a later run without a kick resumes from the held count with a fresh full second.
- R5: A control write with bit 7 set reloads the countdown from the stored timeout and restarts the second. A write of run and kick together starts a full period of timeout seconds. A timeout write while running does not change the live count before the next kick.
- R6: On the tick that ends the last second, the block pulses exactly one output for one cycle: `reset_req` if the action bit held before that cycle is 0, otherwise `poweroff_req`. Run then reads 0.
- R7: The expiry flag is set by an expiry and cleared by writing 1 to control bit 1. `sys_rst` does not clear it; `por_rst` does. `sys_rst` returns every other field to its R1 value.
- R8: Kicks spaced closer than the timeout keep both request outputs low indefinitely.
- R9: A kick in the same cycle as the final tick wins: the countdown reloads and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_rst | input | 1 | Synchronous power-on reset, clears all state |
| sys_rst | input | 1 | Synchronous system reset, keeps the expiry flag |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Byte address in the window; bit 2 selects the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at `bus_addr` (combinational) |
| reset_req | output | 1 | One-cycle system-reset request on expiry |
| poweroff_req | output | 1 | One-cycle power-off request on expiry |

## Verification
A prescaler phase that is off by even one clock moves every expiry pulse by a whole multiple of that error. The bench's per-clock reference model flags it on the first request edge. A countdown that reloads from the wrong source, or fails to hold while stopped, shows as a request that appears too early or never appears. A lost or spuriously cleared expiry flag shows on the very next read of the control word, including right after a system reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int WORD_W   = 32;
    localparam int TMO_W    = 10;
    localparam int ADDR_W   = 3;
    localparam int SEL_BIT  = 2;

    localparam int B_RUN    = 0;
    localparam int B_FIRED  = 1;
    localparam int B_ACT    = 2;
    localparam int B_IDLE   = 3;
    localparam int B_KICK   = 7;

    typedef enum logic {
        ACT_RESET    = 1'b0,
        ACT_POWEROFF = 1'b1
    } action_e;

    typedef struct packed {
        logic    run;
        action_e act;
        logic    fired;
    } ctl_t;

    typedef struct packed {
        logic             wr_ctl;
        logic             wr_tmo;
        logic             kick;
        logic             run_req;
        action_e          act;
        logic             fired_clr;
        logic [TMO_W-1:0] tmo;
    } bus_cmd_t;

    function automatic logic [TMO_W-1:0] clamp_tmo(input logic [WORD_W-1:0] d);
        logic [TMO_W-1:0] v;
        v = d[TMO_W-1:0];
        return (v == '0) ? TMO_W'(1) : v;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctl(input ctl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[B_RUN]   = c.run;
        w[B_FIRED] = c.fired;
        w[B_ACT]   = c.act;
        w[B_IDLE]  = ~c.run;
        return w;
    endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DEFAULT_TIMEOUT = 60
) (
    input  logic                  clk,
    input  logic                  por_rst,
    input  logic                  sys_rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    input  logic                  expire,
    output ctl_t                  ctl_q,
    output logic [TMO_W-1:0]      tmo_q,
    output logic                  kick,
    output logic                  run_after,
    output logic                  run_next,
    output logic [WORD_W-1:0]     bus_rdata
);
    localparam logic [TMO_W-1:0] TMO_RST = TMO_W'(DEFAULT_TIMEOUT);

    bus_cmd_t cmd;
    logic     run_q;
    action_e  act_q;
    logic     fired_q;
    logic     soft_rst;

    assign soft_rst = por_rst | sys_rst;

    always_comb begin
        cmd.wr_ctl    = bus_wr & ~bus_addr[SEL_BIT];
        cmd.wr_tmo    = bus_wr &  bus_addr[SEL_BIT];
        cmd.kick      = cmd.wr_ctl & bus_wdata[B_KICK];
        cmd.run_req   = bus_wdata[B_RUN];
        cmd.act       = action_e'(bus_wdata[B_ACT]);
        cmd.fired_clr = cmd.wr_ctl & bus_wdata[B_FIRED];
        cmd.tmo       = clamp_tmo(bus_wdata);
    end

    assign kick      = cmd.kick;
    assign run_after = cmd.wr_ctl ? cmd.run_req : run_q;
    assign run_next  = run_after & ~expire;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            fired_q <= 1'b0;
        end else if (expire) begin
            fired_q <= 1'b1;
        end else if (cmd.fired_clr) begin
            fired_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (soft_rst) begin
            run_q <= 1'b0;
            act_q <= ACT_RESET;
            tmo_q <= TMO_RST;
        end else begin
            run_q <= run_next;
            if (cmd.wr_ctl) begin
                act_q <= cmd.act;
            end
            if (cmd.wr_tmo) begin
                tmo_q <= cmd.tmo;
            end
        end
    end

    always_comb begin
        ctl_q.run   = run_q;
        ctl_q.act   = act_q;
        ctl_q.fired = fired_q;
    end

    always_comb begin
        if (bus_addr[SEL_BIT]) begin
            bus_rdata = WORD_W'(tmo_q);
        end else begin
            bus_rdata = pack_ctl(ctl_q);
        end
    end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int TICKS_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_q,
    input  logic clr,
    output logic tick
);
    localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PW-1:0] LIM = PW'(TICKS_PER_SEC - 1);

    logic [PW-1:0] phase_q;

    assign tick = run_q & (phase_q == LIM);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (phase_q == LIM) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_pkg::*;
#(
    parameter int DEFAULT_TIMEOUT = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             kick,
    input  logic             run_after,
    input  action_e          act,
    input  logic [TMO_W-1:0] tmo,
    output logic [TMO_W-1:0] count_q,
    output logic             expire,
    output logic             reset_req,
    output logic             poweroff_req
);
    localparam logic [TMO_W-1:0] CNT_RST = TMO_W'(DEFAULT_TIMEOUT);

    logic step;
    logic last_sec;

    assign step     = tick & run_after & ~kick;
    assign last_sec = (count_q <= TMO_W'(1));
    assign expire   = step & last_sec;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= CNT_RST;
        end else if (kick) begin
            count_q <= tmo;
        end else if (step) begin
            count_q <= last_sec ? '0 : count_q - TMO_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reset_req    <= 1'b0;
            poweroff_req <= 1'b0;
        end else begin
            reset_req    <= expire & (act == ACT_RESET);
            poweroff_req <= expire & (act == ACT_POWEROFF);
        end
    end
endmodule

// File: rtl/wdog_window.sv
module wdog_window
    import wdog_pkg::*;
#(
    parameter int TICKS_PER_SEC   = 50_000_000,
    parameter int DEFAULT_TIMEOUT = 60
) (
    input  logic                  clk,
    input  logic                  por_rst,
    input  logic                  sys_rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic                  reset_req,
    output logic                  poweroff_req
);
    ctl_t             ctl_q;
    logic [TMO_W-1:0] tmo_q;
    logic [TMO_W-1:0] count_q;
    logic             kick_w;
    logic             run_after_w;
    logic             run_next_w;
    logic             expire_w;
    logic             tick_w;
    logic             any_rst;

    assign any_rst = por_rst | sys_rst;

    wdog_regs #(
        .DEFAULT_TIMEOUT(DEFAULT_TIMEOUT)
    ) u_regs (
        .clk       (clk),
        .por_rst   (por_rst),
        .sys_rst   (sys_rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .expire    (expire_w),
        .ctl_q     (ctl_q),
        .tmo_q     (tmo_q),
        .kick      (kick_w),
        .run_after (run_after_w),
        .run_next  (run_next_w),
        .bus_rdata (bus_rdata)
    );

    wdog_prescale #(
        .TICKS_PER_SEC(TICKS_PER_SEC)
    ) u_pre (
        .clk   (clk),
        .rst   (any_rst),
        .run_q (ctl_q.run),
        .clr   (~run_next_w | kick_w),
        .tick  (tick_w)
    );

    wdog_countdown #(
        .DEFAULT_TIMEOUT(DEFAULT_TIMEOUT)
    ) u_cnt (
        .clk          (clk),
        .rst          (any_rst),
        .tick         (tick_w),
        .kick         (kick_w),
        .run_after    (run_after_w),
        .act          (ctl_q.act),
        .tmo          (tmo_q),
        .count_q      (count_q),
        .expire       (expire_w),
        .reset_req    (reset_req),
        .poweroff_req (poweroff_req)
    );
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run_q,
    input logic             act_q,
    input logic             fired_q,
    input logic             kick,
    input logic             expire,
    input logic [TMO_W-1:0] tmo_q,
    input logic [TMO_W-1:0] count_q,
    input logic             reset_req,
    input logic             poweroff_req
);
    p_req_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(reset_req && poweroff_req));

    p_reset_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    p_poweroff_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        poweroff_req |=> !poweroff_req);

    p_action_sel_r6: assert property (@(posedge clk) disable iff (rst)
        (expire && act_q) |=> poweroff_req);

    p_expire_stops_r6: assert property (@(posedge clk) disable iff (rst)
        expire |=> !run_q);

    p_req_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (reset_req || poweroff_req) |-> fired_q);

    p_tmo_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        tmo_q != '0);

    p_hold_stopped_r4: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !kick) |=> $stable(count_q));

    p_kick_reload_r5: assert property (@(posedge clk) disable iff (rst)
        kick |=> (count_q == $past(tmo_q)));

    p_kick_beats_expiry_r9: assert property (@(posedge clk) disable iff (rst)
        kick |-> !expire);
endmodule

bind wdog_window wdog_window_chk u_chk (
    .clk          (clk),
    .rst          (por_rst | sys_rst),
    .run_q        (ctl_q.run),
    .act_q        (ctl_q.act),
    .fired_q      (ctl_q.fired),
    .kick         (kick_w),
    .expire       (expire_w),
    .tmo_q        (tmo_q),
    .count_q      (count_q),
    .reset_req    (reset_req),
    .poweroff_req (poweroff_req)
);

// File: tb/wdog_window_test.sv
module wdog_window_test;
    localparam int TPS = 6;
    localparam int DEF = 5;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        sys_rst = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        reset_req;
    logic        poweroff_req;

    int n_cmp = 0;
    int n_bad = 0;
    int n_rreq = 0;
    int n_preq = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state
    int m_run = 0, m_act = 0, m_fired = 0, m_tmo = DEF, m_cnt = DEF, m_pre = 0;
    int m_rq = 0, m_pq = 0;

    wdog_window #(.TICKS_PER_SEC(TPS), .DEFAULT_TIMEOUT(DEF)) uut (
        .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .reset_req(reset_req), .poweroff_req(poweroff_req)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        if (a[2]) return 32'(m_tmo);
        return 32'(m_run) | (32'(m_fired) << 1) | (32'(m_act) << 2) | (32'(m_run == 0) << 3);
    endfunction

    // per-clock reference model and comparison
    always @(posedge clk) begin
        logic s_wr, s_por, s_sys;
        logic [2:0] s_addr;
        logic [31:0] s_wd;
        int wc, wt, kick, tick, ra, ex, rn, v;
        s_wr = bus_wr; s_addr = bus_addr; s_wd = bus_wdata;
        s_por = por_rst; s_sys = sys_rst;
        #2;
        cycles++;
        if (s_por || s_sys) begin
            m_run = 0; m_act = 0; m_tmo = DEF; m_cnt = DEF; m_pre = 0;
            m_rq = 0; m_pq = 0;
            if (s_por) m_fired = 0;
        end else begin
            wc = (s_wr && !s_addr[2]) ? 1 : 0;
            wt = (s_wr && s_addr[2]) ? 1 : 0;
            kick = (wc != 0 && s_wd[7]) ? 1 : 0;
            tick = (m_run != 0 && m_pre == TPS - 1) ? 1 : 0;
            ra = (wc != 0) ? int'(s_wd[0]) : m_run;
            ex = (kick == 0 && tick != 0 && ra != 0 && m_cnt <= 1) ? 1 : 0;
            m_rq = (ex != 0 && m_act == 0) ? 1 : 0;
            m_pq = (ex != 0 && m_act != 0) ? 1 : 0;
            if (kick != 0) m_cnt = m_tmo;
            else if (tick != 0 && ra != 0) m_cnt = (m_cnt <= 1) ? 0 : m_cnt - 1;
            rn = (ra != 0 && ex == 0) ? 1 : 0;
            if (rn == 0 || kick != 0) m_pre = 0;
            else if (m_pre == TPS - 1) m_pre = 0;
            else m_pre = m_pre + 1;
            if (ex != 0) m_fired = 1;
            else if (wc != 0 && s_wd[1]) m_fired = 0;
            if (wc != 0) m_act = int'(s_wd[2]);
            m_run = rn;
            if (wt != 0) begin
                v = int'(s_wd[9:0]);
                m_tmo = (v == 0) ? 1 : v;
            end
        end
        if (reset_req) n_rreq++;
        if (poweroff_req) n_preq++;
        chk("R6 reset_req", 32'(reset_req), 32'(m_rq));
        chk("R6 poweroff_req", 32'(poweroff_req), 32'(m_pq));
        chk(bus_addr[2] ? "R3 timeout word" : "R2 control word", bus_rdata, model_rd(bus_addr));
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_addr = bus_addr ^ 3'd4;
        end
    endtask

    task automatic expect_rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        por_rst = 1'b0;
        // R1: reset state
        expect_rd("R1 control after power-on", 3'd0, 32'h0000_0008);
        expect_rd("R1 timeout after power-on", 3'd4, 32'(DEF));
        chk("R1 requests low", {30'd0, reset_req, poweroff_req}, 32'd0);

        // R3: clamping and masking
        wr(3'd4, 32'd0);
        expect_rd("R3 zero clamps to one", 3'd4, 32'd1);
        wr(3'd4, 32'h0000_1403);
        expect_rd("R3 upper bits dropped", 3'd4, 32'd3);
        wr(3'd4, 32'h0000_0400);
        expect_rd("R3 masked zero clamps", 3'd4, 32'd1);

        // R2: field layout
        wr(3'd0, 32'h0000_0004);
        expect_rd("R2 action bit with idle flag", 3'd0, 32'h0000_000C);
        wr(3'd0, 32'h0000_0000);

        // R6: reset-request expiry after 3 s
        wr(3'd4, 32'd3);
        n_rreq = 0; n_preq = 0;
        wr(3'd0, 32'h0000_0081);
        expect_rd("R2 kick bit reads zero while running", 3'd0, 32'h0000_0001);
        idle(24);
        chk("R6 one reset request", 32'(n_rreq), 32'd1);
        chk("R6 no power-off request", 32'(n_preq), 32'd0);
        expect_rd("R7 flag set, run cleared", 3'd0, 32'h0000_000A);

        // R7: system reset keeps the flag
        @(negedge clk); sys_rst = 1'b1;
        @(negedge clk); sys_rst = 1'b0;
        expect_rd("R7 flag survives system reset", 3'd0, 32'h0000_000A);
        expect_rd("R7 timeout restored by system reset", 3'd4, 32'(DEF));
        wr(3'd0, 32'h0000_0002);
        expect_rd("R7 write-one clears flag", 3'd0, 32'h0000_0008);

        // R8: regular kicks prevent expiry
        wr(3'd4, 32'd2);
        n_rreq = 0; n_preq = 0;
        wr(3'd0, 32'h0000_0085);
        for (int k = 0; k < 6; k++) begin
            idle(8);
            wr(3'd0, 32'h0000_0085);
        end
        chk("R8 no requests while kicked", 32'(n_rreq + n_preq), 32'd0);

        // R4: stop holds, resume without kick
        wr(3'd0, 32'h0000_0004);
        idle(40);
        chk("R4 no requests while stopped", 32'(n_rreq + n_preq), 32'd0);
        expect_rd("R4 stopped control word", 3'd0, 32'h0000_000C);
        wr(3'd0, 32'h0000_0005);
        idle(20);
        chk("R6 one power-off request", 32'(n_preq), 32'd1);
        chk("R6 no reset request in power-off mode", 32'(n_rreq), 32'd0);

        // R5: timeout write while running does not touch live count
        wr(3'd0, 32'h0000_0002);
        wr(3'd4, 32'd4);
        wr(3'd0, 32'h0000_0081);
        idle(2);
        wr(3'd4, 32'd1);
        n_rreq = 0; n_preq = 0;
        idle(15);
        chk("R5 no early expiry after timeout rewrite", 32'(n_rreq), 32'd0);
        idle(15);
        chk("R5 expiry after the original period", 32'(n_rreq), 32'd1);

        // R9: kick on the final tick wins
        wr(3'd0, 32'h0000_0002);
        n_rreq = 0; n_preq = 0;
        wr(3'd0, 32'h0000_0081);
        idle(4);
        wr(3'd0, 32'h0000_0081);
        wr(3'd0, 32'h0000_0000);
        chk("R9 kick on final tick suppresses request", 32'(n_rreq + n_preq), 32'd0);

        // R7: power-on reset clears the flag
        wr(3'd0, 32'h0000_0081);
        idle(10);
        expect_rd("R7 flag set before power-on reset", 3'd0, 32'h0000_000A);
        @(negedge clk); por_rst = 1'b1;
        @(negedge clk); por_rst = 1'b0;
        expect_rd("R7 power-on reset clears flag", 3'd0, 32'h0000_0008);

        idle(3);
        done = 1'b1;
        finish_run();
    end
endmodule